// File: doc/BRIEF.md
# Infrared Remote Frame Decoder

This block turns a stream of timed line events from an infrared receiver into decoded remote-control frames. An upstream edge timer supplies events. Each event is one strobe that carries a level (mark or gap) and the length of that level in microseconds. The decoder follows the standard NEC frame: a long leading mark, a leading gap, then 32 data bits. Each data bit is a short mark followed by a gap, and the length of the gap gives the bit value.

Each phase has its own acceptance window around its nominal length. The windows are set from one base time unit of 562 µs. An event with the wrong level, or with a length that falls outside its window, drops the decoder back to waiting for a leading mark. After the 32nd bit the decoder reports the frame for one cycle. It gives two codes in the bit order the key tables downstream expect, plus a flag that marks a command byte whose complement byte does not match. A frame with a bad command check is still reported.

Top module: `nec_frame_decoder`

## Requirements
- R1: After reset, frame_valid, user_code, scan_code and chk_err are all zero. A reset in the middle of a frame discards all progress, so the rest of that frame produces no report.
- R2: While waiting, only a mark event whose length d satisfies 7868 < d < 10116 starts a frame. Gap events and marks outside that range are ignored.
- R3: After the leading mark, the next event must be a gap with 3934 < d < 5058. Any other event returns the decoder to waiting.
- R4: Each data mark must satisfy 281 < d < 843. Otherwise the decoder returns to waiting.
- R5: Each data gap with 1405 < d < 1967 enters a 1, and a data gap with 281 < d < 843 enters a 0. Bits enter at the bottom of a 32-bit word that shifts toward the top, so the first bit received ends at bit 31 of the raw word. A gap in neither range returns the decoder to waiting.
- R6: An event whose level is not the one the current phase expects returns the decoder to waiting. A gap is expected after the leading mark and after each data mark. A mark is expected after each data gap.
- R7: frame_valid is high for exactly one cycle. That cycle follows the clock edge that accepts the 32nd data gap. The decoder then waits for a new leading mark, and user_code, scan_code and chk_err hold their values until the next report.
- R8: user_code is the 16-bit bit reversal of raw bits [31:16]. Output bit i equals raw bit 31-i.
- R9: scan_code is the upper byte of the 16-bit bit reversal of raw bits [15:0]. Output bit i equals raw bit 7-i.
- R10: chk_err is 1 exactly when raw[15:8] XOR raw[7:0] differs from 8'hFF. The frame is reported either way.
- R11: Cycles with ev_valid low change nothing, so any number of idle cycles may separate events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ev_valid | input | 1 | Event strobe, one cycle per measured level |
| ev_level | input | 1 | 1 = mark (carrier present), 0 = gap |
| ev_dur | input | 16 | Event length in microseconds |
| frame_valid | output | 1 | One-cycle strobe for a completed frame |
| user_code | output | 16 | Bit-reversed address pair |
| scan_code | output | 8 | Upper byte of the bit-reversed command pair |
| chk_err | output | 1 | Command byte and its complement do not match |

## Verification
An accept state that is wrong by one phase, or a bit counter that is off by one, shows at the ports as a frame that never reports. It can also show as a report one bit early with codes shifted by one place. Either fault is visible within the 66 events of a single frame. A window bound that is off by one microsecond only shows when an event length sits exactly on that bound, so every window is driven at both edges and one step inside each edge. A slip in bit order or in the reversal corrupts user_code or scan_code on the first frame. The bench therefore sweeps all 256 command values and compares every code against values computed arithmetically.

// File: rtl/nec_rx_pkg.sv
package nec_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_HSPACE = 2'd1,
    ST_BPULSE = 2'd2,
    ST_BSPACE = 2'd3
  } nec_state_e;

  // acceptance window table: nominal length in units and margin in half units
  localparam int NUM_WIN       = 5;
  localparam int WIN_HDR_PULSE = 0;
  localparam int WIN_HDR_SPACE = 1;
  localparam int WIN_BIT_PULSE = 2;
  localparam int WIN_ONE_SPACE = 3;
  localparam int WIN_ZERO_SPACE = 4;

  localparam int WIN_CENTER_U [NUM_WIN] = '{16, 8, 1, 3, 1};
  localparam int WIN_HALVES   [NUM_WIN] = '{4, 2, 1, 1, 1};

endpackage

// File: rtl/nec_rst_sync.sv
module nec_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/nec_dur_window.sv
module nec_dur_window #(
  parameter int DUR_W    = 16,
  parameter int UNIT_US  = 562,
  parameter int CENTER_U = 1,
  parameter int HALVES   = 1
) (
  input  logic [DUR_W-1:0] dur,
  output logic             hit
);
  localparam int NOM    = CENTER_U * UNIT_US;
  localparam int MARGIN = (HALVES * UNIT_US) / 2;
  localparam logic [31:0] LO_V = 32'(NOM - MARGIN);
  localparam logic [31:0] HI_V = 32'(NOM + MARGIN);

  logic [31:0] dur32;

  always_comb begin
    dur32 = 32'(dur);
    hit   = (dur32 > LO_V) && (dur32 < HI_V);
  end
endmodule

// File: rtl/nec_bit_shift.sv
module nec_bit_shift #(
  parameter int NBITS = 32,
  localparam int CW   = $clog2(NBITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             shift_en,
  input  logic             bit_in,
  output logic [NBITS-1:0] word_next,
  output logic [CW-1:0]    cnt,
  output logic             last
);
  logic [NBITS-1:0] word_q, word_d;
  logic [CW-1:0]    cnt_d;

  always_comb begin
    word_next = {word_q[NBITS-2:0], bit_in};
    word_d    = word_q;
    cnt_d     = cnt;
    if (clr) begin
      cnt_d = '0;
    end else if (shift_en) begin
      word_d = word_next;
      cnt_d  = last ? '0 : cnt + 1'b1;
    end
  end

  assign last = (cnt == CW'(NBITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      cnt    <= '0;
    end else if (clr || shift_en) begin
      word_q <= word_d;
      cnt    <= cnt_d;
    end
  end
endmodule

// File: rtl/nec_code_fmt.sv
module nec_code_fmt #(
  parameter int NBITS = 32,
  localparam int FW   = NBITS / 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [NBITS-1:0] raw,
  output logic            frame_valid,
  output logic [2*FW-1:0] user_code,
  output logic [FW-1:0]   scan_code,
  output logic            chk_err
);
  logic [2*FW-1:0] addr_pair, cmd_pair, addr_rev, cmd_rev;
  logic [FW-1:0]   cmd_b, ncmd_b;
  logic            err_d;

  assign addr_pair = raw[NBITS-1 -: 2*FW];
  assign cmd_pair  = raw[2*FW-1:0];
  assign cmd_b     = cmd_pair[2*FW-1:FW];
  assign ncmd_b    = cmd_pair[FW-1:0];

  for (genvar i = 0; i < 2*FW; i++) begin : g_rev
    assign addr_rev[i] = addr_pair[2*FW-1-i];
    assign cmd_rev[i]  = cmd_pair[2*FW-1-i];
  end

  assign err_d = ((cmd_b ^ ncmd_b) != {FW{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_valid <= 1'b0;
    else        frame_valid <= load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      user_code <= '0;
      scan_code <= '0;
      chk_err   <= 1'b0;
    end else if (load) begin
      user_code <= addr_rev;
      scan_code <= cmd_rev[2*FW-1:FW];
      chk_err   <= err_d;
    end
  end

  // R7: the report strobe never lasts two cycles
  assert_one_cycle_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);

  // R7: codes change only in the cycle a report is made
  assert_codes_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid |-> $stable(user_code) || $past(!rst_n));
endmodule

// File: rtl/nec_frame_decoder.sv
module nec_frame_decoder
  import nec_rx_pkg::*;
#(
  parameter int UNIT_US = 562,
  parameter int DUR_W   = 16,
  parameter int NBITS   = 32,
  localparam int FW     = NBITS / 4,
  localparam int CW     = $clog2(NBITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_valid,
  input  logic             ev_level,
  input  logic [DUR_W-1:0] ev_dur,
  output logic             frame_valid,
  output logic [2*FW-1:0]  user_code,
  output logic [FW-1:0]    scan_code,
  output logic             chk_err
);
  logic             rst_i;
  nec_state_e       state, state_d;
  logic [NUM_WIN-1:0] win;
  logic             clr_cnt, shift_en, load, last;
  logic [NBITS-1:0] word_next;
  logic [CW-1:0]    cnt;

  nec_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_i));

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    nec_dur_window #(
      .DUR_W(DUR_W), .UNIT_US(UNIT_US),
      .CENTER_U(WIN_CENTER_U[w]), .HALVES(WIN_HALVES[w])
    ) u_win (.dur(ev_dur), .hit(win[w]));
  end

  // next-state process
  always_comb begin
    state_d  = state;
    clr_cnt  = 1'b0;
    shift_en = 1'b0;
    load     = 1'b0;
    if (ev_valid) begin
      case (state)
        ST_IDLE: begin
          if (ev_level && win[WIN_HDR_PULSE]) begin
            state_d = ST_HSPACE;
            clr_cnt = 1'b1;
          end
        end
        ST_HSPACE: state_d = (!ev_level && win[WIN_HDR_SPACE]) ? ST_BPULSE : ST_IDLE;
        ST_BPULSE: state_d = (ev_level && win[WIN_BIT_PULSE]) ? ST_BSPACE : ST_IDLE;
        ST_BSPACE: begin
          if (!ev_level && (win[WIN_ONE_SPACE] || win[WIN_ZERO_SPACE])) begin
            shift_en = 1'b1;
            if (last) begin
              load    = 1'b1;
              state_d = ST_IDLE;
            end else begin
              state_d = ST_BPULSE;
            end
          end else begin
            state_d = ST_IDLE;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i)        state <= ST_IDLE;
    else if (ev_valid) state <= state_d;
  end

  nec_bit_shift #(.NBITS(NBITS)) u_shift (
    .clk(clk), .rst_n(rst_i), .clr(clr_cnt), .shift_en(shift_en),
    .bit_in(win[WIN_ONE_SPACE]), .word_next(word_next), .cnt(cnt), .last(last)
  );

  nec_code_fmt #(.NBITS(NBITS)) u_fmt (
    .clk(clk), .rst_n(rst_i), .load(load), .raw(word_next),
    .frame_valid(frame_valid), .user_code(user_code),
    .scan_code(scan_code), .chk_err(chk_err)
  );

  // R2: the bit counter is at zero whenever the leading gap is awaited
  assert_header_clears_count_R2: assert property (@(posedge clk) disable iff (!rst_i)
    (state == ST_HSPACE) |-> (cnt == '0));

  // R6: a level mismatch outside the waiting state always aborts
  assert_level_abort_R6: assert property (@(posedge clk) disable iff (!rst_i)
    (ev_valid && ((state == ST_HSPACE && ev_level) || (state == ST_BPULSE && !ev_level) ||
                  (state == ST_BSPACE && ev_level))) |=> (state == ST_IDLE));

  // R7: a report follows an accepted data gap and leaves the decoder waiting
  assert_strobe_source_R7: assert property (@(posedge clk) disable iff (!rst_i)
    frame_valid |-> ($past(state) == ST_BSPACE) && $past(ev_valid) && (state == ST_IDLE));

  // R11: no event, no state change
  assert_hold_without_event_R11: assert property (@(posedge clk) disable iff (!rst_i)
    !ev_valid |=> $stable(state));
endmodule

// File: tb/nec_frame_decoder_tb.sv
module nec_frame_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ev_valid, ev_level;
  logic [15:0] ev_dur;
  logic        frame_valid, chk_err;
  logic [15:0] user_code;
  logic [7:0]  scan_code;

  int n_tests = 0, n_fail = 0;
  int n_frames = 0, n_double = 0;
  logic [15:0] cap_user;
  logic [7:0]  cap_scan;
  logic        cap_err, prev_fv = 1'b0;
  bit          jitter = 1'b0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  nec_frame_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_level(ev_level), .ev_dur(ev_dur),
    .frame_valid(frame_valid), .user_code(user_code), .scan_code(scan_code), .chk_err(chk_err)
  );

  always @(negedge clk) begin
    if (frame_valid) begin
      n_frames++;
      cap_user = user_code;
      cap_scan = scan_code;
      cap_err  = chk_err;
      if (prev_fv) n_double++;
    end
    prev_fv = frame_valid;
  end

  function automatic logic [15:0] flip16(input logic [15:0] v);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = v[15 - i];
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] jit(input int nom);
    int d = nom;
    if (jitter) d = nom + int'($urandom_range(400)) - 200;
    return 16'(d);
  endfunction

  task automatic send_ev(input logic lvl, input logic [15:0] d);
    @(negedge clk);
    ev_valid = 1'b1; ev_level = lvl; ev_dur = d;
    @(negedge clk);
    ev_valid = 1'b0;
    if (jitter) repeat ($urandom_range(2)) @(negedge clk);
  endtask

  // phase: 0 none, 1 lead mark, 2 lead gap, 3 data mark idx, 4 data gap idx
  task automatic send_frame(input logic [31:0] raw, input int phase, input int idx,
                            input logic lvl, input logic [15:0] d, input bit hdr,
                            input int first, input int lastb);
    if (hdr) begin
      if (phase == 1) send_ev(lvl, d); else send_ev(1'b1, jit(8992));
      if (phase == 2) send_ev(lvl, d); else send_ev(1'b0, jit(4496));
    end
    for (int k = first; k <= lastb; k++) begin
      if (phase == 3 && idx == k) send_ev(lvl, d); else send_ev(1'b1, jit(562));
      if (phase == 4 && idx == k) send_ev(lvl, d);
      else send_ev(1'b0, raw[31 - k] ? jit(1686) : jit(562));
    end
  endtask

  task automatic run_frame(input logic [31:0] raw, input int phase, input int idx,
                           input logic lvl, input logic [15:0] d, input bit exp_ok, input string req);
    int base = n_frames;
    send_frame(raw, phase, idx, lvl, d, 1'b1, 0, 31);
    @(negedge clk); #1;
    check((n_frames - base) == (exp_ok ? 1 : 0), req, n_frames - base, exp_ok ? 1 : 0);
    if (exp_ok && (n_frames - base) == 1) begin
      check(cap_user == flip16(raw[31:16]), "R8", cap_user, flip16(raw[31:16]));
      check(cap_scan == flip16(raw[15:0])  >> 8, "R9", cap_scan, flip16(raw[15:0]) >> 8);
      check(cap_err == ((raw[15:8] ^ raw[7:0]) != 8'hFF), "R10", cap_err,
            (raw[15:8] ^ raw[7:0]) != 8'hFF);
    end
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] base_raw = 32'hA55A_34CB;
    logic [31:0] r1, r0;
    int base;
    ev_valid = 1'b0; ev_level = 1'b0; ev_dur = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset values
    check(!frame_valid && user_code == 0 && scan_code == 0 && !chk_err, "R1",
          {frame_valid, chk_err, user_code, scan_code}, 0);

    // basic frame, nominal lengths
    run_frame(base_raw, 0, 0, 1'b0, 16'd0, 1'b1, "R5");
    // R7 next frame needs a new header: 32 bits alone do nothing
    base = n_frames;
    send_frame(base_raw, 0, 0, 1'b0, 0, 1'b0, 0, 31);
    @(negedge clk); #1;
    check(n_frames == base, "R7", n_frames - base, 0);
    // R2/R7 stray gaps in the waiting state: no report, codes hold
    for (int s = 0; s < 4; s++) send_ev(1'b0, 16'd8992);
    check(n_frames == base && cap_user == flip16(base_raw[31:16]) &&
          user_code == flip16(base_raw[31:16]), "R2", user_code, flip16(base_raw[31:16]));

    // R2 lead mark window
    run_frame(base_raw, 1, 0, 1'b1, 16'd7868,  1'b0, "R2");
    run_frame(base_raw, 1, 0, 1'b1, 16'd7869,  1'b1, "R2");
    run_frame(base_raw, 1, 0, 1'b1, 16'd10115, 1'b1, "R2");
    run_frame(base_raw, 1, 0, 1'b1, 16'd10116, 1'b0, "R2");
    run_frame(base_raw, 1, 0, 1'b0, 16'd8992,  1'b0, "R2");
    // R3 lead gap window
    run_frame(base_raw, 2, 0, 1'b0, 16'd3934, 1'b0, "R3");
    run_frame(base_raw, 2, 0, 1'b0, 16'd3935, 1'b1, "R3");
    run_frame(base_raw, 2, 0, 1'b0, 16'd5057, 1'b1, "R3");
    run_frame(base_raw, 2, 0, 1'b0, 16'd5058, 1'b0, "R3");
    // R4 data mark window
    run_frame(base_raw, 3, 5, 1'b1, 16'd281, 1'b0, "R4");
    run_frame(base_raw, 3, 5, 1'b1, 16'd282, 1'b1, "R4");
    run_frame(base_raw, 3, 5, 1'b1, 16'd842, 1'b1, "R4");
    run_frame(base_raw, 3, 5, 1'b1, 16'd843, 1'b0, "R4");
    // R5 one-gap window at bit index 7 (raw bit 24), zero-gap at index 9 (raw bit 22)
    r1 = base_raw; r1[24] = 1'b1;
    r0 = base_raw; r0[22] = 1'b0;
    run_frame(r1, 4, 7, 1'b0, 16'd1405, 1'b0, "R5");
    run_frame(r1, 4, 7, 1'b0, 16'd1406, 1'b1, "R5");
    run_frame(r1, 4, 7, 1'b0, 16'd1966, 1'b1, "R5");
    run_frame(r1, 4, 7, 1'b0, 16'd1967, 1'b0, "R5");
    run_frame(r0, 4, 9, 1'b0, 16'd281,  1'b0, "R5");
    run_frame(r0, 4, 9, 1'b0, 16'd282,  1'b1, "R5");
    run_frame(r0, 4, 9, 1'b0, 16'd842,  1'b1, "R5");
    run_frame(r0, 4, 9, 1'b0, 16'd843,  1'b0, "R5");
    run_frame(r0, 4, 9, 1'b0, 16'd1124, 1'b0, "R5");
    run_frame(r1, 4, 31, 1'b0, 16'd1124, 1'b0, "R5");
    // R6 wrong levels
    run_frame(base_raw, 2, 0, 1'b1, 16'd4496, 1'b0, "R6");
    run_frame(base_raw, 3, 12, 1'b0, 16'd562, 1'b0, "R6");
    run_frame(base_raw, 4, 20, 1'b1, 16'd1686, 1'b0, "R6");

    // R1 reset mid-frame discards progress and clears codes
    base = n_frames;
    send_frame(base_raw, 0, 0, 1'b0, 0, 1'b1, 0, 9);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(user_code == 0 && scan_code == 0 && !chk_err, "R1", user_code, 0);
    send_frame(base_raw, 0, 0, 1'b0, 0, 1'b0, 10, 31);
    @(negedge clk); #1;
    check(n_frames == base, "R1", n_frames - base, 0);

    // R8-R11 sweep over every command value with jittered lengths and gaps
    jitter = 1'b1;
    for (int c = 0; c < 256; c++) begin
      logic [7:0] a = 8'(c) ^ 8'h3C;
      logic [7:0] nc = c[1] ? ~8'(c) : (8'(c) ^ 8'h01);
      run_frame({a, c[0] ? ~a : a ^ 8'h80, 8'(c), nc}, 0, 0, 1'b0, 0, 1'b1, "R11");
    end
    check(n_double == 0, "R7", n_double, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule